// File: doc/BRIEF.md
# Paired Opposite-Direction Weight Store

This block holds weights for two neighbouring processing elements in one dual-port memory of `DEPTH` words, which is twice what one element would hold alone. Each element owns one port. Side A fills its region from address 0 upward. Side B fills its region from address `DEPTH-1` downward. Because the two regions grow toward each other, the free space between them belongs to neither side. A side holding long vectors can therefore use room that a side holding short vectors leaves empty.

Each side appends words in order and closes a vector with a "last" marker. A small per-side table records where each closed vector starts and how long it is. Reads name a vector index and an offset inside that vector. The table confines every read to the side's own closed vectors.

When a side has finished computing with its resident block, a release command empties that side so that the next block can be loaded. The other side keeps its data, and may go on computing or loading in the meantime.

Top module: `pbuf_pair`

## Requirements
- R1: After reset both sides report zero used words, zero vectors and a clear overflow flag, and neither read-valid output is high.
- R2: The two sides share `DEPTH` words. A write accepted on one side never alters any word that the other side reads back from its closed vectors, including when the combined fill reaches `DEPTH`.
- R3: A write is accepted only while `a_used + b_used < DEPTH`. A rejected write leaves the used count unchanged and sets that side's overflow flag, which stays set until release.
- R4: When both sides write in the same cycle and exactly one word is free, side A takes the word and side B's write is rejected with overflow.
- R5: Each accepted write advances the side's used count by one. A write with the last marker closes a vector. Vectors are numbered from 0 in closing order, and each vector holds the words written since the previous close.
- R6: A read with `rd_vec` and `rd_off` returns the word written at that position, one clock later, with read-valid high.
- R7: A read whose vector index is not below the side's vector count, or whose offset is not below that vector's length, returns read-valid low.
- R8: If a side has an accepted write and a read in the same cycle, the write is performed and the read returns read-valid low.
- R9: Release sets that side's used count, vector count and overflow flag to zero on the next clock. A write in the same cycle is dropped without overflow. The other side's counts and data are untouched.
- R10: Once a side holds `NVEC` closed vectors, further writes on that side are rejected with overflow until release.
- R11: One side may write while the other reads in the same cycle, and both operations complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_wr_en | input | 1 | Side A append request |
| a_wr_last | input | 1 | Side A write closes the current vector |
| a_wr_data | input | DW | Side A write word |
| a_rd_en | input | 1 | Side A read request |
| a_rd_vec | input | VW | Side A vector index to read |
| a_rd_off | input | AW | Side A offset within the vector |
| a_release | input | 1 | Side A empties its region |
| a_rd_valid | output | 1 | Side A read data valid |
| a_rd_data | output | DW | Side A read word |
| a_used | output | CW | Side A words occupied |
| a_nvec | output | NW | Side A closed vectors |
| a_ovf | output | 1 | Side A sticky overflow |
| b_wr_en | input | 1 | Side B append request |
| b_wr_last | input | 1 | Side B write closes the current vector |
| b_wr_data | input | DW | Side B write word |
| b_rd_en | input | 1 | Side B read request |
| b_rd_vec | input | VW | Side B vector index to read |
| b_rd_off | input | AW | Side B offset within the vector |
| b_release | input | 1 | Side B empties its region |
| b_rd_valid | output | 1 | Side B read data valid |
| b_rd_data | output | DW | Side B read word |
| b_used | output | CW | Side B words occupied |
| b_nvec | output | NW | Side B closed vectors |
| b_ovf | output | 1 | Side B sticky overflow |

## Verification
The most important same-cycle collision is two writes, one per side, arriving when a single word separates the two regions. The bench fills side A until the gap is one word, then raises both write enables in one cycle. It expects side A's count to grow, side B's count to hold and only side B's overflow flag to rise. It then reads back words on both sides of the boundary to show that neither side corrupted the other. Two further same-cycle pairs are checked in the same way through the counts and read-valid outputs: release together with a write on one side, and a read together with a write on one side.

// File: rtl/pbuf_pkg.sv
package pbuf_pkg;
   typedef enum logic {SIDE_UP = 1'b0, SIDE_DOWN = 1'b1} side_dir_e;
endpackage

// File: rtl/pbuf_tdp_ram.sv
module pbuf_tdp_ram #(
   parameter int DW    = 16,
   parameter int DEPTH = 2048,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          p0_en,
   input  logic          p0_we,
   input  logic [AW-1:0] p0_addr,
   input  logic [DW-1:0] p0_wdata,
   output logic [DW-1:0] p0_rdata,
   input  logic          p1_en,
   input  logic          p1_we,
   input  logic [AW-1:0] p1_addr,
   input  logic [DW-1:0] p1_wdata,
   output logic [DW-1:0] p1_rdata
);
   logic [DW-1:0] mem [DEPTH];

   // Both ports in one process; the side logic guarantees disjoint addresses.
   always_ff @(posedge clk) begin
      if (p0_en) begin
         if (p0_we) mem[p0_addr] <= p0_wdata;
         else       p0_rdata     <= mem[p0_addr];
      end
      if (p1_en) begin
         if (p1_we) mem[p1_addr] <= p1_wdata;
         else       p1_rdata     <= mem[p1_addr];
      end
   end
endmodule

// File: rtl/pbuf_side.sv
module pbuf_side
   import pbuf_pkg::*;
#(
   parameter int        DW    = 16,
   parameter int        DEPTH = 2048,
   parameter int        NVEC  = 16,
   parameter side_dir_e DIR   = SIDE_UP,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1),
   localparam int VW = $clog2(NVEC),
   localparam int NW = $clog2(NVEC + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          wr_last,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_en,
   input  logic [VW-1:0] rd_vec,
   input  logic [AW-1:0] rd_off,
   input  logic          rel,
   input  logic [CW-1:0] peer_used,
   input  logic          peer_claim,
   output logic          wr_acc,
   output logic [CW-1:0] used,
   output logic [NW-1:0] nvec,
   output logic          ovf,
   output logic          rd_valid,
   output logic          ram_en,
   output logic          ram_we,
   output logic [AW-1:0] ram_addr,
   output logic [DW-1:0] ram_wdata
);
   logic [CW-1:0] fill_q, vstart_q;
   logic [NW-1:0] vcnt_q;
   logic          ovf_q, rdv_q;
   logic [CW-1:0] base_q [2**VW];
   logic [CW-1:0] len_q  [2**VW];

   logic [CW:0]   demand;
   logic          space_ok, tbl_ok, vec_ok, off_ok, rd_ok;
   logic [CW-1:0] log_addr;

   always_comb begin
      demand   = {1'b0, fill_q} + {1'b0, peer_used} + (CW+1)'(peer_claim);
      space_ok = demand < (CW+1)'(DEPTH);
      tbl_ok   = vcnt_q < NW'(NVEC);
      wr_acc   = wr_en & ~rel & space_ok & tbl_ok;
      vec_ok   = NW'(rd_vec) < vcnt_q;
      off_ok   = CW'(rd_off) < len_q[rd_vec];
      rd_ok    = rd_en & ~wr_acc & vec_ok & off_ok;
      log_addr = wr_acc ? fill_q : (base_q[rd_vec] + CW'(rd_off));
   end

   // Address direction is the variant chosen per side.
   generate
      if (DIR == SIDE_DOWN) begin : g_down
         assign ram_addr = AW'(CW'(DEPTH - 1) - log_addr);
      end else begin : g_up
         assign ram_addr = AW'(log_addr);
      end
   endgenerate

   assign ram_en    = wr_acc | rd_ok;
   assign ram_we    = wr_acc;
   assign ram_wdata = wr_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fill_q   <= '0;
         vstart_q <= '0;
         vcnt_q   <= '0;
         ovf_q    <= 1'b0;
         rdv_q    <= 1'b0;
         for (int i = 0; i < 2**VW; i++) begin
            base_q[i] <= '0;
            len_q[i]  <= '0;
         end
      end else begin
         rdv_q <= rd_ok;
         if (rel) begin
            fill_q   <= '0;
            vstart_q <= '0;
            vcnt_q   <= '0;
            ovf_q    <= 1'b0;
         end else begin
            if (wr_acc) begin
               fill_q <= fill_q + CW'(1);
               if (wr_last) begin
                  base_q[vcnt_q[VW-1:0]] <= vstart_q;
                  len_q[vcnt_q[VW-1:0]]  <= fill_q + CW'(1) - vstart_q;
                  vstart_q               <= fill_q + CW'(1);
                  vcnt_q                 <= vcnt_q + NW'(1);
               end
            end
            if (wr_en && !wr_acc) ovf_q <= 1'b1;
         end
      end
   end

   assign used     = fill_q;
   assign nvec     = vcnt_q;
   assign ovf      = ovf_q;
   assign rd_valid = rdv_q;
endmodule

// File: rtl/pbuf_pair.sv
module pbuf_pair
   import pbuf_pkg::*;
#(
   parameter int DW    = 16,
   parameter int DEPTH = 2048,
   parameter int NVEC  = 16,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1),
   localparam int VW = $clog2(NVEC),
   localparam int NW = $clog2(NVEC + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          a_wr_en,
   input  logic          a_wr_last,
   input  logic [DW-1:0] a_wr_data,
   input  logic          a_rd_en,
   input  logic [VW-1:0] a_rd_vec,
   input  logic [AW-1:0] a_rd_off,
   input  logic          a_release,
   output logic          a_rd_valid,
   output logic [DW-1:0] a_rd_data,
   output logic [CW-1:0] a_used,
   output logic [NW-1:0] a_nvec,
   output logic          a_ovf,
   input  logic          b_wr_en,
   input  logic          b_wr_last,
   input  logic [DW-1:0] b_wr_data,
   input  logic          b_rd_en,
   input  logic [VW-1:0] b_rd_vec,
   input  logic [AW-1:0] b_rd_off,
   input  logic          b_release,
   output logic          b_rd_valid,
   output logic [DW-1:0] b_rd_data,
   output logic [CW-1:0] b_used,
   output logic [NW-1:0] b_nvec,
   output logic          b_ovf
);
   generate
      if (DEPTH < 4)  $error("pbuf_pair: DEPTH must be at least 4");
      if (NVEC < 2)   $error("pbuf_pair: NVEC must be at least 2");
      if (DW < 1)     $error("pbuf_pair: DW must be positive");
      if (NVEC > DEPTH) $error("pbuf_pair: NVEC cannot exceed DEPTH");
   endgenerate

   logic          a_acc, b_acc;
   logic          a_en, a_we, b_en, b_we;
   logic [AW-1:0] a_addr, b_addr;
   logic [DW-1:0] a_wd, b_wd;

   // Side A has priority for the last free word; B sees A's claim.
   pbuf_side #(.DW(DW), .DEPTH(DEPTH), .NVEC(NVEC), .DIR(SIDE_UP)) u_side_a (
      .clk(clk), .rst_n(rst_n),
      .wr_en(a_wr_en), .wr_last(a_wr_last), .wr_data(a_wr_data),
      .rd_en(a_rd_en), .rd_vec(a_rd_vec), .rd_off(a_rd_off), .rel(a_release),
      .peer_used(b_used), .peer_claim(1'b0),
      .wr_acc(a_acc), .used(a_used), .nvec(a_nvec), .ovf(a_ovf), .rd_valid(a_rd_valid),
      .ram_en(a_en), .ram_we(a_we), .ram_addr(a_addr), .ram_wdata(a_wd)
   );

   pbuf_side #(.DW(DW), .DEPTH(DEPTH), .NVEC(NVEC), .DIR(SIDE_DOWN)) u_side_b (
      .clk(clk), .rst_n(rst_n),
      .wr_en(b_wr_en), .wr_last(b_wr_last), .wr_data(b_wr_data),
      .rd_en(b_rd_en), .rd_vec(b_rd_vec), .rd_off(b_rd_off), .rel(b_release),
      .peer_used(a_used), .peer_claim(a_acc),
      .wr_acc(b_acc), .used(b_used), .nvec(b_nvec), .ovf(b_ovf), .rd_valid(b_rd_valid),
      .ram_en(b_en), .ram_we(b_we), .ram_addr(b_addr), .ram_wdata(b_wd)
   );

   pbuf_tdp_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
      .clk(clk),
      .p0_en(a_en), .p0_we(a_we), .p0_addr(a_addr), .p0_wdata(a_wd), .p0_rdata(a_rd_data),
      .p1_en(b_en), .p1_we(b_we), .p1_addr(b_addr), .p1_wdata(b_wd), .p1_rdata(b_rd_data)
   );

   logic unused_acc;
   assign unused_acc = b_acc;
endmodule

// File: rtl/pbuf_pair_chk.sv
module pbuf_pair_chk #(
   parameter int DEPTH = 2048,
   parameter int NVEC  = 16,
   localparam int CW = $clog2(DEPTH + 1),
   localparam int NW = $clog2(NVEC + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          a_wr_en,
   input logic          a_release,
   input logic          a_rd_en,
   input logic          a_rd_valid,
   input logic [CW-1:0] a_used,
   input logic [NW-1:0] a_nvec,
   input logic          a_ovf,
   input logic          b_wr_en,
   input logic          b_release,
   input logic          b_rd_en,
   input logic          b_rd_valid,
   input logic [CW-1:0] b_used,
   input logic [NW-1:0] b_nvec,
   input logic          b_ovf
);
   logic [CW:0] total;
   assign total = {1'b0, a_used} + {1'b0, b_used};

   p_shared_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      total <= (CW+1)'(DEPTH));

   p_full_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (a_wr_en && !a_release && total == (CW+1)'(DEPTH))
      |=> (a_ovf && a_used == $past(a_used)));

   p_tie_b_loses_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (a_wr_en && b_wr_en && !a_release && !b_release
       && a_nvec < NW'(NVEC) && total == (CW+1)'(DEPTH - 1))
      |=> (b_ovf && b_used == $past(b_used)));

   p_grow_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !a_release |=> (a_used == $past(a_used) || a_used == $past(a_used) + CW'(1)));

   p_rdv_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      b_rd_valid |-> $past(b_rd_en));

   p_release_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
      a_release |=> (a_used == '0 && a_nvec == '0 && !a_ovf));

   p_release_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
      b_release |=> (b_used == '0 && b_nvec == '0 && !b_ovf));

   p_vec_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (a_nvec <= NW'(NVEC)) && (b_nvec <= NW'(NVEC)));

   logic unused_in;
   assign unused_in = a_rd_en ^ a_rd_valid;
endmodule

bind pbuf_pair pbuf_pair_chk #(.DEPTH(DEPTH), .NVEC(NVEC)) u_chk (.*);

// File: tb/sim_pbuf_pair.sv
`timescale 1ns/1ps
module sim_pbuf_pair;
   localparam int DW = 16, DEPTH = 16, NVEC = 4;
   localparam int AW = $clog2(DEPTH), CW = $clog2(DEPTH + 1);
   localparam int VW = $clog2(NVEC),  NW = $clog2(NVEC + 1);

   logic clk = 1'b0, rst_n = 1'b0;
   logic a_wr_en = 0, a_wr_last = 0, a_rd_en = 0, a_release = 0;
   logic b_wr_en = 0, b_wr_last = 0, b_rd_en = 0, b_release = 0;
   logic [DW-1:0] a_wr_data = '0, b_wr_data = '0;
   logic [VW-1:0] a_rd_vec = '0, b_rd_vec = '0;
   logic [AW-1:0] a_rd_off = '0, b_rd_off = '0;
   logic a_rd_valid, b_rd_valid, a_ovf, b_ovf;
   logic [DW-1:0] a_rd_data, b_rd_data;
   logic [CW-1:0] a_used, b_used;
   logic [NW-1:0] a_nvec, b_nvec;

   int checks = 0, fails = 0;
   bit done = 0;

   always #4 clk = ~clk;

   pbuf_pair #(.DW(DW), .DEPTH(DEPTH), .NVEC(NVEC)) u0 (.*);

   task automatic chk(input string tag, input int got, input int exp);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
      end
   endtask

   task automatic wr(input bit sb, input int d, input bit last);
      if (!sb) begin a_wr_en = 1; a_wr_data = DW'(d); a_wr_last = last; end
      else     begin b_wr_en = 1; b_wr_data = DW'(d); b_wr_last = last; end
      @(negedge clk);
      a_wr_en = 0; a_wr_last = 0; b_wr_en = 0; b_wr_last = 0;
   endtask

   task automatic rd(input bit sb, input int vec, input int off,
                     output bit v, output int d);
      if (!sb) begin a_rd_en = 1; a_rd_vec = VW'(vec); a_rd_off = AW'(off); end
      else     begin b_rd_en = 1; b_rd_vec = VW'(vec); b_rd_off = AW'(off); end
      @(negedge clk);
      a_rd_en = 0; b_rd_en = 0;
      v = sb ? b_rd_valid : a_rd_valid;
      d = sb ? int'(b_rd_data) : int'(a_rd_data);
   endtask

   task automatic rd_expect(input string tag, input bit sb, input int vec,
                            input int off, input int exp);
      bit v; int d;
      rd(sb, vec, off, v, d);
      chk({tag, " valid"}, v, 1);
      chk({tag, " data"}, d, exp);
   endtask

   task automatic rd_reject(input string tag, input bit sb, input int vec, input int off);
      bit v; int d;
      rd(sb, vec, off, v, d);
      chk(tag, v, 0);
   endtask

   task automatic t_reset;
      chk("R1 a_used", a_used, 0);   chk("R1 b_used", b_used, 0);
      chk("R1 a_nvec", a_nvec, 0);   chk("R1 b_ovf", b_ovf, 0);
      chk("R1 a_ovf", a_ovf, 0);     chk("R1 rd_valid", a_rd_valid | b_rd_valid, 0);
   endtask

   task automatic t_fill_a;
      wr(0, 100, 0); wr(0, 101, 0); wr(0, 102, 1);
      wr(0, 200, 0); wr(0, 201, 1);
      chk("R5 a_used", a_used, 5);
      chk("R5 a_nvec", a_nvec, 2);
      rd_expect("R6 a v1o1", 0, 1, 1, 201);
      rd_expect("R6 a v0o0", 0, 0, 0, 100);
      rd_expect("R5 a v0o2", 0, 0, 2, 102);
   endtask

   task automatic t_fill_b;
      for (int i = 0; i < 4; i++) wr(1, 300 + i, i == 3);
      chk("R5 b_used", b_used, 4);
      chk("R5 b_nvec", b_nvec, 1);
      rd_expect("R6 b v0o3", 1, 0, 3, 303);
      rd_expect("R2 a intact", 0, 0, 2, 102);
   endtask

   task automatic t_bounds;
      rd_reject("R7 a vec beyond count", 0, 2, 0);
      rd_reject("R7 a off beyond len", 0, 1, 2);
      rd_reject("R7 b vec beyond count", 1, 1, 0);
   endtask

   task automatic t_tie_and_full;
      for (int i = 0; i < 6; i++) wr(0, 400 + i, i == 5);
      chk("R3 a_used before tie", a_used, 11);
      a_wr_en = 1; a_wr_data = 16'd406; b_wr_en = 1; b_wr_data = 16'd304;
      @(negedge clk);
      a_wr_en = 0; b_wr_en = 0;
      chk("R4 a_used", a_used, 12);
      chk("R4 b_used", b_used, 4);
      chk("R4 b_ovf", b_ovf, 1);
      chk("R4 a_ovf", a_ovf, 0);
      wr(0, 407, 0);
      chk("R3 a_ovf", a_ovf, 1);
      chk("R3 a_used held", a_used, 12);
      rd_expect("R2 a v2o5", 0, 2, 5, 405);
      rd_expect("R2 b v0o0", 1, 0, 0, 300);
      rd_expect("R2 b v0o3", 1, 0, 3, 303);
   endtask

   task automatic t_release_b;
      b_release = 1; @(negedge clk); b_release = 0;
      chk("R9 b_used", b_used, 0);
      chk("R9 b_nvec", b_nvec, 0);
      chk("R9 b_ovf", b_ovf, 0);
      chk("R9 a_used kept", a_used, 12);
      chk("R9 a_ovf kept", a_ovf, 1);
      rd_reject("R9 b empty", 1, 0, 0);
   endtask

   task automatic t_concurrent;
      a_rd_en = 1; a_rd_vec = 0; a_rd_off = 1;
      b_wr_en = 1; b_wr_data = 16'd500; b_wr_last = 1;
      @(negedge clk);
      a_rd_en = 0; b_wr_en = 0; b_wr_last = 0;
      chk("R11 a valid", a_rd_valid, 1);
      chk("R11 a data", a_rd_data, 101);
      chk("R11 b_used", b_used, 1);
      chk("R11 b_nvec", b_nvec, 1);
   endtask

   task automatic t_rw_same_side;
      b_wr_en = 1; b_wr_data = 16'd501;
      b_rd_en = 1; b_rd_vec = 0; b_rd_off = 0;
      @(negedge clk);
      b_wr_en = 0; b_rd_en = 0;
      chk("R8 b read dropped", b_rd_valid, 0);
      chk("R8 b_used", b_used, 2);
      rd_expect("R8 b v0o0 after", 1, 0, 0, 500);
   endtask

   task automatic t_release_with_write;
      a_release = 1; a_wr_en = 1; a_wr_data = 16'd600;
      @(negedge clk);
      a_release = 0; a_wr_en = 0;
      chk("R9 a_used", a_used, 0);
      chk("R9 a_ovf", a_ovf, 0);
      chk("R9 a_nvec", a_nvec, 0);
      chk("R9 b_used kept", b_used, 2);
      rd_expect("R9 b data kept", 1, 0, 0, 500);
   endtask

   task automatic t_table_full;
      for (int i = 0; i < NVEC; i++) wr(0, 700 + i, 1);
      chk("R10 a_nvec", a_nvec, NVEC);
      wr(0, 799, 1);
      chk("R10 a_ovf", a_ovf, 1);
      chk("R10 a_used", a_used, NVEC);
      rd_expect("R10 a v3", 0, 3, 0, 703);
      rd_expect("R10 a v0", 0, 0, 0, 700);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset;
      t_fill_a;
      t_fill_b;
      t_bounds;
      t_tie_and_full;
      t_release_b;
      t_concurrent;
      t_rw_same_side;
      t_release_with_write;
      t_table_full;
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule